// File: doc/BRIEF.md
# Double-Buffered Output Compare Channel

This block is one compare channel of a timer. A 16-bit compare value comes in over an 8-bit CPU write bus. The upper byte is parked in a temporary byte. The lower-byte write then moves both halves into the target register in a single clock edge, so the comparator never sees a half-updated value. The channel compares the external counter value against its active compare register on every clock. A match raises a sticky flag and, according to a 2-bit output-mode field, sets, clears or toggles the output pin.

When the PWM select is high, CPU writes land in a shadow buffer. The buffer is copied into the active register only on a cycle where the counter reports its top or bottom, so a period is never cut short. When the select is low, writes go straight to the active register. In that case a force strobe can also drive the pin exactly as a match would, without touching the flag.

Top module: `oc_chan`

## Requirements
- R1: After reset the temporary byte, buffer, active compare value, match flag and output latch are all zero, and `ocEn` is low while `comMode` is 00.
- R2: A strobe on `wrHi` stores `busWrData` in the temporary byte only; the value that `rdData` returns does not change.
- R3: With `pwmMode` low, a strobe on `wrLo` loads the active register with {temporary byte, `busWrData`} at that clock edge.
- R4: With `pwmMode` high, `wrLo` loads the buffer instead, and the active register takes the buffer value only at an edge where `atTop` or `atBottom` is high.
- R5: `matchFlag` goes high at the clock edge after a cycle in which `counter` equals the active value, and it stays high afterwards.
- R6: A `flagClr` strobe clears `matchFlag` at the next edge, unless a match is present in that same cycle, in which case the flag stays set.
- R7: At the edge after a match, `comMode` 01 toggles `ocOut`, 10 drives it low and 11 drives it high. With 00, `ocOut` holds its value and `ocEn` is low; `ocEn` is high for any other mode.
- R8: With `pwmMode` low, `forceCmp` acts on `ocOut` as a match would, under the same `comMode` coding, but it does not set `matchFlag`.
- R9: With `pwmMode` high, `forceCmp` has no effect on `ocOut`.
- R10: `rdData` returns the upper byte when `rdHi` is 1 and the lower byte when it is 0. The byte comes from the buffer when `pwmMode` is high and from the active register otherwise, and the read never goes through the temporary byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWrData | input | 8 | CPU write data byte |
| wrHi | input | 1 | Upper-byte write strobe (to temporary byte) |
| wrLo | input | 1 | Lower-byte write strobe (commits 16 bits) |
| rdHi | input | 1 | Read byte select: 1 upper, 0 lower |
| rdData | output | 8 | Read data byte |
| pwmMode | input | 1 | 1 selects a PWM waveform mode (buffering on) |
| comMode | input | 2 | Output action on match: 00 off, 01 toggle, 10 clear, 11 set |
| counter | input | 16 | Running timer count |
| atTop | input | 1 | Counter is at its top value this cycle |
| atBottom | input | 1 | Counter is at its bottom value this cycle |
| forceCmp | input | 1 | Force-compare strobe |
| flagClr | input | 1 | Write-one strobe that clears the flag |
| matchFlag | output | 1 | Sticky compare-match flag |
| ocOut | output | 1 | Output pin latch |
| ocEn | output | 1 | Output pin enable |

## Verification
The bench builds the channel with its default 8-bit bus, which gives a 16-bit compare value. Byte-lane handling is therefore exercised across a real split: distinct upper and lower patterns such as 0xABCD and 0x1234 show that each byte lands in its own half. The small width also lets the bench steer the counter onto and off the compare value in single cycles. It can then place a match, a flag clear, a force and a top or bottom commit on chosen edges, and check where these collide.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [1:0] {
    PIN_HOLD   = 2'd0,
    PIN_TOGGLE = 2'd1,
    PIN_CLEAR  = 2'd2,
    PIN_SET    = 2'd3
  } pinOp_e;

  typedef struct packed {
    logic   loadTemp;
    logic   loadBuf;
    logic   loadAct;
    logic   commit;
    logic   flagSet;
    logic   flagClr;
    pinOp_e pinOp;
  } ocCtrl_t;
endpackage

// File: rtl/oc_ctrl.sv
module oc_ctrl
  import oc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrHi,
  input  logic       wrLo,
  input  logic       pwmMode,
  input  logic       atTop,
  input  logic       atBottom,
  input  logic       forceCmp,
  input  logic       flagClrWr,
  input  logic [1:0] comMode,
  input  logic       cmpEq,
  output ocCtrl_t    st,
  output logic       ocEn
);
  logic fire;

  assign fire = cmpEq || (forceCmp && !pwmMode);
  assign ocEn = (comMode != 2'b00);

  always_comb begin
    st          = '0;
    st.loadTemp = wrHi;
    st.loadBuf  = wrLo && pwmMode;
    st.loadAct  = wrLo && !pwmMode;
    st.commit   = pwmMode && (atTop || atBottom);
    st.flagSet  = cmpEq;
    st.flagClr  = flagClrWr;
    st.pinOp    = PIN_HOLD;
    if (fire) begin
      case (comMode)
        2'b01:   st.pinOp = PIN_TOGGLE;
        2'b10:   st.pinOp = PIN_CLEAR;
        2'b11:   st.pinOp = PIN_SET;
        default: st.pinOp = PIN_HOLD;
      endcase
    end
  end

  // R9
  force_pwm_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwmMode && !cmpEq) |-> (st.pinOp == PIN_HOLD));

  // R8
  force_no_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (forceCmp && !cmpEq) |-> !st.flagSet);
endmodule

// File: rtl/oc_dpath.sv
module oc_dpath
  import oc_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ocCtrl_t              st,
  input  logic [BUS_W-1:0]     busWrData,
  input  logic [2*BUS_W-1:0]   counter,
  input  logic                 rdHi,
  input  logic                 pwmMode,
  output logic [BUS_W-1:0]     rdData,
  output logic                 cmpEq,
  output logic                 matchFlag,
  output logic                 ocOut
);
  localparam int CMP_W = 2 * BUS_W;

  logic [BUS_W-1:0] tempByte;
  logic [CMP_W-1:0] bufReg;
  logic [CMP_W-1:0] actReg;
  logic [CMP_W-1:0] wrWord;
  logic [CMP_W-1:0] rdView;

  assign wrWord = {tempByte, busWrData};
  assign cmpEq  = (counter == actReg);
  assign rdView = pwmMode ? bufReg : actReg;
  assign rdData = rdHi ? rdView[CMP_W-1:BUS_W] : rdView[BUS_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tempByte <= '0;
      bufReg   <= '0;
      actReg   <= '0;
    end else begin
      if (st.loadTemp) tempByte <= busWrData;
      if (st.loadBuf)  bufReg   <= wrWord;
      if (st.loadAct)       actReg <= wrWord;
      else if (st.commit)   actReg <= bufReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchFlag <= 1'b0;
      ocOut     <= 1'b0;
    end else begin
      if (st.flagSet)      matchFlag <= 1'b1;
      else if (st.flagClr) matchFlag <= 1'b0;
      case (st.pinOp)
        PIN_TOGGLE: ocOut <= !ocOut;
        PIN_CLEAR:  ocOut <= 1'b0;
        PIN_SET:    ocOut <= 1'b1;
        default:    ocOut <= ocOut;
      endcase
    end
  end

  // R2
  temp_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.loadTemp && !st.loadAct && !st.commit) |=> $stable(actReg));

  // R3
  direct_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.loadAct |=> (actReg == {$past(tempByte), $past(busWrData)}));

  // R4
  commit_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.commit && !st.loadAct) |=> (actReg == $past(bufReg)));

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmpEq |=> matchFlag);

  // R6
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.flagClr && !cmpEq) |=> !matchFlag);

  // R7
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.pinOp == PIN_HOLD) |=> $stable(ocOut));

  // R7
  pin_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.pinOp == PIN_SET) |=> ocOut);
endmodule

// File: rtl/oc_chan.sv
module oc_chan
  import oc_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int CMP_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [BUS_W-1:0] busWrData,
  input  logic             wrHi,
  input  logic             wrLo,
  input  logic             rdHi,
  output logic [BUS_W-1:0] rdData,
  input  logic             pwmMode,
  input  logic [1:0]       comMode,
  input  logic [CMP_W-1:0] counter,
  input  logic             atTop,
  input  logic             atBottom,
  input  logic             forceCmp,
  input  logic             flagClr,
  output logic             matchFlag,
  output logic             ocOut,
  output logic             ocEn
);
  ocCtrl_t st;
  logic    cmpEq;

  oc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrHi(wrHi), .wrLo(wrLo), .pwmMode(pwmMode),
    .atTop(atTop), .atBottom(atBottom), .forceCmp(forceCmp),
    .flagClrWr(flagClr), .comMode(comMode), .cmpEq(cmpEq),
    .st(st), .ocEn(ocEn)
  );

  oc_dpath #(.BUS_W(BUS_W)) u_dpath (
    .clk(clk), .rstN(rstN), .st(st), .busWrData(busWrData),
    .counter(counter), .rdHi(rdHi), .pwmMode(pwmMode),
    .rdData(rdData), .cmpEq(cmpEq), .matchFlag(matchFlag), .ocOut(ocOut)
  );
endmodule

// File: tb/oc_chan_bench.sv
module oc_chan_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busWrData = '0;
  logic        wrHi = 1'b0, wrLo = 1'b0, rdHi = 1'b0;
  logic [7:0]  rdData;
  logic        pwmMode = 1'b0;
  logic [1:0]  comMode = 2'b00;
  logic [15:0] counter = 16'hFFFF;
  logic        atTop = 1'b0, atBottom = 1'b0, forceCmp = 1'b0, flagClr = 1'b0;
  logic        matchFlag, ocOut, ocEn;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference state
  int mTemp = 0, mBuf = 0, mAct = 0;
  bit mFlag = 0, mOut = 0;

  always #10 clk = ~clk;

  oc_chan u_oc_chan (
    .clk(clk), .rstN(rstN), .busWrData(busWrData), .wrHi(wrHi), .wrLo(wrLo),
    .rdHi(rdHi), .rdData(rdData), .pwmMode(pwmMode), .comMode(comMode),
    .counter(counter), .atTop(atTop), .atBottom(atBottom), .forceCmp(forceCmp),
    .flagClr(flagClr), .matchFlag(matchFlag), .ocOut(ocOut), .ocEn(ocEn)
  );

  always @(posedge clk) begin
    automatic bit eq = (int'(counter) == mAct);
    automatic bit fire;
    automatic int nAct = mAct;
    if (!rstN) begin
      mTemp = 0; mBuf = 0; mAct = 0; mFlag = 0; mOut = 0;
    end else begin
      if (wrLo) begin
        if (pwmMode) mBuf = mTemp * 256 + int'(busWrData);
        else         nAct = mTemp * 256 + int'(busWrData);
      end else if (pwmMode && (atTop || atBottom)) begin
        nAct = mBuf;
      end
      if (wrHi) mTemp = int'(busWrData);
      if (eq) mFlag = 1;
      else if (flagClr) mFlag = 0;
      fire = eq || (forceCmp && !pwmMode);
      if (fire) begin
        if (comMode == 2'b01) mOut = !mOut;
        else if (comMode == 2'b10) mOut = 0;
        else if (comMode == 2'b11) mOut = 1;
      end
      mAct = nAct;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      automatic int view = pwmMode ? mBuf : mAct;
      chk(int'(rdData), rdHi ? (view / 256) : (view % 256), "R10 model rdData");
      chk(int'(matchFlag), int'(mFlag), "R5 model flag");
      chk(int'(ocOut), int'(mOut), "R7 model pin");
      chk(int'(ocEn), int'(comMode != 2'b00), "R7 model enable");
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic writeHi(input logic [7:0] d);
    busWrData = d; wrHi = 1'b1; tick(); wrHi = 1'b0;
  endtask

  task automatic writeLo(input logic [7:0] d);
    busWrData = d; wrLo = 1'b1; tick(); wrLo = 1'b0;
  endtask

  task automatic hitCount(input logic [15:0] v);
    counter = v; tick(); counter = 16'hFFFF;
  endtask

  task automatic readWord(output int w);
    rdHi = 1'b1; #1; w = int'(rdData) * 256;
    rdHi = 1'b0; #1; w = w + int'(rdData);
  endtask

  task automatic summary();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int w;
    tick(); tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    readWord(w);           chk(w, 0, "R1 compare value");
    chk(int'(matchFlag), 0, "R1 flag");
    chk(int'(ocOut), 0, "R1 pin");
    chk(int'(ocEn), 0, "R1 enable");

    // R2 upper byte only reaches the temporary byte
    writeHi(8'hAB);
    readWord(w);           chk(w, 0, "R2 value unchanged after high write");

    // R3 direct load in non-PWM mode
    writeLo(8'hCD);
    readWord(w);           chk(w, 16'hABCD, "R3 direct load");

    // R5 flag after match, sticky
    comMode = 2'b11;
    hitCount(16'hABCD);
    chk(int'(matchFlag), 1, "R5 flag set");
    chk(int'(ocOut), 1, "R7 set on match");
    tick(); tick();
    chk(int'(matchFlag), 1, "R5 flag sticky");

    // R6 clear, and set wins against clear
    flagClr = 1'b1; tick(); flagClr = 1'b0;
    chk(int'(matchFlag), 0, "R6 flag cleared");
    flagClr = 1'b1; counter = 16'hABCD; tick(); flagClr = 1'b0; counter = 16'hFFFF;
    chk(int'(matchFlag), 1, "R6 set beats clear");

    // R7 output modes
    comMode = 2'b01; hitCount(16'hABCD);
    chk(int'(ocOut), 0, "R7 toggle low");
    hitCount(16'hABCD);
    chk(int'(ocOut), 1, "R7 toggle high");
    comMode = 2'b10; hitCount(16'hABCD);
    chk(int'(ocOut), 0, "R7 clear");
    comMode = 2'b11; hitCount(16'hABCD);
    chk(int'(ocOut), 1, "R7 set");
    comMode = 2'b00; hitCount(16'hABCD);
    chk(int'(ocOut), 1, "R7 off holds");
    chk(int'(ocEn), 0, "R7 off enable low");

    // R8 force in non-PWM mode
    comMode = 2'b01;
    flagClr = 1'b1; tick(); flagClr = 1'b0;
    forceCmp = 1'b1; tick(); forceCmp = 1'b0;
    chk(int'(ocOut), 0, "R8 force toggles");
    chk(int'(matchFlag), 0, "R8 force leaves flag");

    // R9 force ignored in PWM mode
    pwmMode = 1'b1;
    forceCmp = 1'b1; tick(); forceCmp = 1'b0;
    chk(int'(ocOut), 0, "R9 force ignored");
    tick();
    chk(int'(ocOut), 0, "R9 pin still held");

    // R4 buffered write, commit at top
    writeHi(8'h12); writeLo(8'h34);
    readWord(w);           chk(w, 16'h1234, "R10 buffer read in PWM");
    hitCount(16'h1234);
    chk(int'(matchFlag), 0, "R4 no mid-period update");
    hitCount(16'hABCD);
    chk(int'(matchFlag), 1, "R4 old value still active");
    flagClr = 1'b1; tick(); flagClr = 1'b0;
    atTop = 1'b1; tick(); atTop = 1'b0;
    hitCount(16'h1234);
    chk(int'(matchFlag), 1, "R4 commit at top");

    // R4 commit at bottom
    flagClr = 1'b1; tick(); flagClr = 1'b0;
    writeHi(8'h56); writeLo(8'h78);
    hitCount(16'h5678);
    chk(int'(matchFlag), 0, "R4 held before bottom");
    atBottom = 1'b1; tick(); atBottom = 1'b0;
    hitCount(16'h5678);
    chk(int'(matchFlag), 1, "R4 commit at bottom");
    pwmMode = 1'b0;
    readWord(w);           chk(w, 16'h5678, "R10 active read");

    tick(); tick();
    summary();
  end
endmodule